// File: doc/BRIEF.md
# RTC Periodic Interrupt Generator

This block collects ten periodic timekeeping events and turns them into latched flags and one interrupt request line. The events are the fast prescaler tick rates (32 Hz, 8 Hz, 4 Hz, 1 Hz) and the carries of the time counters (10 seconds, 1 minute, 10 minutes, 1 hour, half day, 1 day). Each event arrives as a one-clock pulse from logic outside this block.

Software programs a 16-bit enable word through a small register port. An event only latches its flag while its enable bit is set. The request line stays high while any flag is both set and enabled. Software clears a flag by writing a 1 to its bit in the flag word. The interrupt controller that receives the request is outside this block.

Top module: `rtc_irq_gen`

## Requirements
- R1: After reset the enable word, the flag word and `irq` are all zero.
- R2: Address 0 holds the enable word. Bits 0 to 9 belong, in this order, to 32 Hz, 8 Hz, 4 Hz, 1 Hz, 10 s, 1 min, 10 min, 1 h, half day and 1 day, which are also `evt_pulse` bits 0 to 9. A write stores bits 9:0 and a read returns them.
- R3: Bits 15:10 read as 0 at every address, whatever was written.
- R4: An event pulse on bit i while enable bit i is 1 makes flag bit i (address 1, same bit position) read 1 from the next cycle.
- R5: An event pulse on bit i while enable bit i is 0 leaves flag bit i at 0.
- R6: `irq` is 1 exactly when some bit is 1 in both the flag word and the enable word. Clearing an enable bit drops its part of the request, and the flag stays set.
- R7: Writing the flag word clears every flag whose write-data bit is 1 and leaves the flags with write-data bit 0 unchanged.
- R8: If a clear and an enabled event hit the same flag in the same cycle, the flag is 1 afterwards.
- R9: A set flag stays set, and keeps `irq` high while it is enabled, until it is cleared.
- R10: Addresses 2 and 3 read as 0, and writes to them change nothing.
- R11: An event is gated by the enable value held before the clock edge. An enable write in the same cycle as the event first takes effect on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_pulse | input | 10 | One-clock event pulses, bit order as in R2 |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | 2 | Register address: 0 = enable word, 1 = flag word |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Interrupt request |

## Verification
Event pulses come from a bench model of the divider chain. The fast rates recur often, and the carries arrive together with their lower-rate neighbours, so the bench sees both single-source and coincident multi-source sets. Random enable and flag writes go to all four addresses in between. The mix separates correct gating at set time from gating only at the request, and separates write-one-to-clear from a plain write. Directed cases cover a clear that collides with an event, an enable that changes in the same cycle as an event, and a disable with a flag still pending. These show whether the event or the clear wins, which enable value gates the event, and whether the request is masked while the flag is kept.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
  localparam int NUM_SRC_D = 10;
  localparam int REG_W_D   = 16;
  localparam int ADDR_W_D  = 2;

  // register addresses
  localparam int ADDR_ENABLE = 0;
  localparam int ADDR_FLAGS  = 1;

  // per-source flag update: an enabled event wins over a clear
  function automatic logic step_flag(input logic cur, input logic en,
                                     input logic evt, input logic clr);
    return (cur & ~clr) | (evt & en);
  endfunction

  // request term: flag counts only while enabled
  function automatic logic req_term(input logic flag, input logic en);
    return flag & en;
  endfunction
endpackage

// File: rtl/rtc_irq_regif.sv
module rtc_irq_regif #(
  parameter int NUM_SRC = rtc_irq_pkg::NUM_SRC_D,
  parameter int REG_W   = rtc_irq_pkg::REG_W_D,
  parameter int ADDR_W  = rtc_irq_pkg::ADDR_W_D
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [REG_W-1:0]   bus_wdata,
  input  logic [NUM_SRC-1:0] flag_vec,
  output logic [NUM_SRC-1:0] en_q,
  output logic [NUM_SRC-1:0] clr_vec,
  output logic [REG_W-1:0]   bus_rdata
);
  localparam int PAD_W = REG_W - NUM_SRC;

  logic sel_en, sel_flag, wr_en;

  assign sel_en   = (bus_addr == ADDR_W'(rtc_irq_pkg::ADDR_ENABLE));
  assign sel_flag = (bus_addr == ADDR_W'(rtc_irq_pkg::ADDR_FLAGS));
  assign wr_en    = bus_wr & sel_en;
  assign clr_vec  = (bus_wr & sel_flag) ? bus_wdata[NUM_SRC-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (wr_en) en_q <= bus_wdata[NUM_SRC-1:0];
  end

  always_comb begin
    bus_rdata = '0;
    if (sel_en)        bus_rdata = {{PAD_W{1'b0}}, en_q};
    else if (sel_flag) bus_rdata = {{PAD_W{1'b0}}, flag_vec};
  end

  // R10: a write to an unmapped address leaves the enable word alone
  a_r10_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !sel_en && !sel_flag) |=> $stable(en_q));
  // R2: a write to the enable word shows up in the following cycle
  a_r2_enable_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (en_q == $past(bus_wdata[NUM_SRC-1:0])));
endmodule

// File: rtl/rtc_irq_flag_cell.sv
module rtc_irq_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic en,
  input  logic clr,
  output logic flag_q
);
  logic flag_d;

  assign flag_d = rtc_irq_pkg::step_flag(flag_q, en, evt, clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  // R5: a disabled source never sets its flag
  a_r5_no_set_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !flag_q) |=> !flag_q);
  // R8: event beats clear in the same cycle
  a_r8_event_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && en && clr) |=> flag_q);
  // R7: clear without a competing event empties the flag
  a_r7_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && clr && !(evt && en)) |=> !flag_q);
  // R9: a flag holds until cleared
  a_r9_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr) |=> flag_q);
  // R4: an enabled event sets the flag
  a_r4_enabled_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && en) |=> flag_q);
endmodule

// File: rtl/rtc_irq_req.sv
module rtc_irq_req #(
  parameter int NUM_SRC = rtc_irq_pkg::NUM_SRC_D
) (
  input  logic [NUM_SRC-1:0] flag_vec,
  input  logic [NUM_SRC-1:0] en_vec,
  output logic               irq
);
  logic [NUM_SRC-1:0] live;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_term
    assign live[i] = rtc_irq_pkg::req_term(flag_vec[i], en_vec[i]);
  end

  assign irq = |live;
endmodule

// File: rtl/rtc_irq_gen.sv
module rtc_irq_gen #(
  parameter int NUM_SRC = rtc_irq_pkg::NUM_SRC_D,
  parameter int REG_W   = rtc_irq_pkg::REG_W_D,
  parameter int ADDR_W  = rtc_irq_pkg::ADDR_W_D
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] evt_pulse,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [REG_W-1:0]   bus_wdata,
  output logic [REG_W-1:0]   bus_rdata,
  output logic               irq
);
  // named internal events, brought out for the assertions
  logic [NUM_SRC-1:0] en_q;
  logic [NUM_SRC-1:0] clr_vec;
  logic [NUM_SRC-1:0] flag_vec;

  rtc_irq_regif #(.NUM_SRC(NUM_SRC), .REG_W(REG_W), .ADDR_W(ADDR_W)) u_regif (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .flag_vec(flag_vec), .en_q(en_q),
    .clr_vec(clr_vec), .bus_rdata(bus_rdata)
  );

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    rtc_irq_flag_cell u_cell (
      .clk(clk), .rst_n(rst_n), .evt(evt_pulse[i]), .en(en_q[i]),
      .clr(clr_vec[i]), .flag_q(flag_vec[i])
    );
  end

  rtc_irq_req #(.NUM_SRC(NUM_SRC)) u_req (
    .flag_vec(flag_vec), .en_vec(en_q), .irq(irq)
  );

  // R3: reserved upper bits always read zero
  a_r3_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[REG_W-1:NUM_SRC] == '0);
  // R6: nothing enabled means no request
  a_r6_quiet_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !irq);
  // R9: a request with no clear pending persists
  a_r9_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && clr_vec == '0 && !(bus_wr && bus_addr == ADDR_W'(rtc_irq_pkg::ADDR_ENABLE))) |=> irq);
endmodule

// File: tb/rtc_irq_gen_bench.sv
`timescale 1ns/1ps
module rtc_irq_gen_bench;
  localparam int N = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [N-1:0] evt_pulse = '0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq;

  int total = 0;
  int bad = 0;
  logic [N-1:0] en_m = '0;
  logic [N-1:0] flag_m = '0;

  // divider chain state
  int c32 = 0, s_c = 9, t10s_c = 5, m_c = 9, t10m_c = 5, h_c = 11, hd_c = 1;
  int half = 0;

  always #2.5 clk = ~clk;

  rtc_irq_gen u_rtc_irq_gen (
    .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  function automatic logic [N-1:0] exp_flags(logic [N-1:0] f, logic [N-1:0] e,
                                             logic [N-1:0] ev, logic [N-1:0] c);
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) r[i] = ev[i] ? (e[i] | (f[i] & ~c[i])) : (f[i] & ~c[i]);
    return r;
  endfunction

  function automatic logic exp_irq(logic [N-1:0] f, logic [N-1:0] e);
    return (f & e) != '0;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [15:0] act,
                       input logic [15:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // one clock: drive at negedge, update model at posedge, compare just after
  task automatic step(input logic [N-1:0] ev, input logic wr, input logic [1:0] a,
                      input logic [15:0] wd, input string tag);
    logic [N-1:0] clr;
    @(negedge clk);
    evt_pulse = ev; bus_wr = wr; bus_addr = a; bus_wdata = wd;
    @(posedge clk);
    #0.5;
    clr = (wr && a == 2'd1) ? wd[N-1:0] : '0;
    flag_m = exp_flags(flag_m, en_m, ev, clr);
    if (wr && a == 2'd0) en_m = wd[N-1:0];
    evt_pulse = '0; bus_wr = 1'b0; bus_addr = 2'd1;
    #0.5;
    check(bus_rdata == {6'd0, flag_m}, {tag, " flags (R4 R5 R7)"}, bus_rdata, {6'd0, flag_m});
    bus_addr = 2'd0;
    #0.5;
    check(bus_rdata == {6'd0, en_m}, {tag, " enable (R2 R3)"}, bus_rdata, {6'd0, en_m});
    check(irq == exp_irq(flag_m, en_m), {tag, " irq (R6 R9)"}, 16'(irq), 16'(exp_irq(flag_m, en_m)));
  endtask

  // next event vector from the divider chain (32 Hz tick every other cycle)
  function automatic logic [N-1:0] chain_tick();
    logic [N-1:0] e = '0;
    half ^= 1;
    if (half == 0) return e;
    e[0] = 1'b1;
    if (c32 % 4 == 3) e[1] = 1'b1;
    if (c32 % 8 == 7) e[2] = 1'b1;
    if (c32 == 31) begin
      e[3] = 1'b1;
      if (s_c == 9) begin
        e[4] = 1'b1; s_c = 0;
        if (t10s_c == 5) begin
          e[5] = 1'b1; t10s_c = 0;
          if (m_c == 9) begin
            e[6] = 1'b1; m_c = 0;
            if (t10m_c == 5) begin
              e[7] = 1'b1; t10m_c = 0;
              if (h_c == 11) begin
                e[8] = 1'b1; h_c = 0;
                if (hd_c == 1) begin e[9] = 1'b1; hd_c = 0; end
                else hd_c++;
              end else h_c++;
            end else t10m_c++;
          end else m_c++;
        end else t10s_c++;
      end else s_c++;
    end
    c32 = (c32 + 1) % 32;
    return e;
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    #1;
    // R1: reset state
    bus_addr = 2'd0; #0.5;
    check(bus_rdata == 16'h0, "R1 enable after reset", bus_rdata, 16'h0);
    check(irq == 1'b0, "R1 irq after reset", 16'(irq), 16'h0);
    bus_addr = 2'd1; #0.5;
    check(bus_rdata == 16'h0, "R1 flags after reset", bus_rdata, 16'h0);
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R2/R3: full write, reserved bits read back zero
    step('0, 1'b1, 2'd0, 16'hFFFF, "R2 R3 all ones");
    step('0, 1'b1, 2'd0, 16'h0000, "R2 clear enable");
    // R5: event while disabled
    step(10'h3FF, 1'b0, 2'd0, 16'h0, "R5 disabled events");
    // R4: enable 1 Hz (bit 3) and 1 day (bit 9), pulse them
    step('0, 1'b1, 2'd0, 16'h0208, "R2 enable 1Hz+1day");
    step(10'h208, 1'b0, 2'd0, 16'h0, "R4 enabled events");
    // R9: flags hold across idle cycles
    step('0, 1'b0, 2'd0, 16'h0, "R9 hold 1");
    step('0, 1'b0, 2'd0, 16'h0, "R9 hold 2");
    // R6: disabling masks irq, flag remains
    step('0, 1'b1, 2'd0, 16'h0000, "R6 disable pending");
    step('0, 1'b1, 2'd0, 16'h0208, "R6 re-enable pending");
    // R7: clear only bit 3
    step('0, 1'b1, 2'd1, 16'h0008, "R7 partial clear");
    // R8: clear and event collide on bit 9
    step(10'h200, 1'b1, 2'd1, 16'h0200, "R8 event beats clear");
    step('0, 1'b1, 2'd1, 16'hFFFF, "R7 clear all");
    // R10: unmapped addresses
    step('0, 1'b1, 2'd2, 16'hFFFF, "R10 write addr2");
    step('0, 1'b1, 2'd3, 16'hFFFF, "R10 write addr3");
    @(negedge clk); bus_addr = 2'd2; #0.5;
    check(bus_rdata == 16'h0, "R10 read addr2", bus_rdata, 16'h0);
    bus_addr = 2'd3; #0.5;
    check(bus_rdata == 16'h0, "R10 read addr3", bus_rdata, 16'h0);
    // R11: enable write concurrent with event uses old enable
    step('0, 1'b1, 2'd0, 16'h0000, "R11 setup");
    step(10'h001, 1'b1, 2'd0, 16'h0001, "R11 same-cycle enable");
    step(10'h001, 1'b0, 2'd0, 16'h0, "R11 next-cycle event");

    // constrained random: chain events with random register traffic
    for (int k = 0; k < 6000; k++) begin
      logic [N-1:0] ev;
      logic wr;
      logic [1:0] a;
      logic [15:0] wd;
      ev = chain_tick();
      wr = ($urandom % 4) == 0;
      a  = 2'($urandom % 4);
      wd = 16'($urandom);
      if (a == 2'd1 && ($urandom % 2) == 0) wd = wd & 16'h0155;
      step(ev, wr, a, wd, "random");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule